// File: doc/BRIEF.md
# Clock Frequency Source Selector

This block chooses the frequency setting that a clock synthesizer runs from, and it signals each time that setting changes. When the active-low power-good input goes low for the first time after reset, the block captures a 5-bit strap code from the configuration pins and enables its outputs. From then on the setting comes from one of three sources. The first is the captured strap code. The second is a 5-bit select code written by software. The third is a pair of N/M divider values written by software. In that third case the output frequency is G×(N+3)/(M+3), and G and the divide ratios still come from one of the two 5-bit codes.

Software writes single bytes through a write-strobe port. A watchdog can request recovery. When the recovery guard is armed, the request locks the block onto a recovery setting: either the strap code or a separate recovery N/M pair. While the lock holds, the block ignores every write that would move the frequency. The lock ends when software disarms the guard. A one-cycle change strobe marks each accepted frequency update. A one-cycle error pulse marks a rejected divider pair.

Top module: `freq_src_sel`

## Requirements
- R1: After reset, ready_o is 0 and code_o, n_o, m_o, spread_o and prog_mode_o are all 0. On the first clock edge that samples pwrgd_ni low, strap_i is captured and ready_o goes to 1 and stays there. Later changes on strap_i have no effect.
- R2: Byte 0 (address 0) holds the software select code at these bit positions: SEL0 at bit 4, SEL1 at bit 5, SEL2 at bit 6, SEL3 at bit 1, SEL4 at bit 2. The override bit is bit 3. spread_o equals {bit 7, bit 0}.
- R3: With programming disabled, prog_mode_o is 0 and n_o and m_o are 0. code_o is the software select code when the override bit is 1 and the captured strap code when it is 0.
- R4: With programming enabled, prog_mode_o is 1 and n_o and m_o show the programmed pair. code_o still follows the override bit.
- R5: The address map is: 1 = programmed N; 2 = {program enable at bit 7, M[6:0]}; 3 = recovery N; 4 = {recovery select at bit 7, recovery M[6:0]}; 5 = bit 0 arms the recovery guard.
- R6: A write is rejected when it would leave an enabled pair with N+3 ≤ M+3. This applies to an N write while that pair is enabled, and to an M write with bit 7 set. A rejected write changes nothing, pulses err_o for one cycle and gives no strobe.
- R7: chg_o pulses for one cycle in the cycle after every accepted write to address 0, 1 or 2, even when the value written is identical. Writes to addresses 3 to 5 give no strobe, except the unlock case in R11.
- R8: A recovery request while armed and unlocked sets locked_o and pulses chg_o in the next cycle. A request while unarmed or already locked does nothing.
- R9: While locked with recovery select 0, code_o is the strap code and prog_mode_o is 0. While locked with select 1, prog_mode_o is 1, n_o and m_o show the recovery pair, and code_o follows the override bit.
- R10: While locked, writes to addresses 0 to 4 are ignored: no strobe, no error, no output change.
- R11: Writing address 5 with bit 0 = 0 disarms the guard and clears the lock. If the block was locked, chg_o pulses once.
- R12: Writes made before ready_o is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwrgd_ni | input | 1 | Power good, active low; triggers strap capture |
| strap_i | input | 5 | Strap code pins |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 8 | Register write data |
| recover_req_i | input | 1 | Watchdog recovery request |
| ready_o | output | 1 | Strap captured, outputs enabled |
| code_o | output | 5 | Active 5-bit frequency select code |
| prog_mode_o | output | 1 | N/M divider values in use |
| n_o | output | 8 | Active N value (0 when not in use) |
| m_o | output | 7 | Active M value (0 when not in use) |
| spread_o | output | 2 | Spread select field |
| chg_o | output | 1 | One-cycle frequency change strobe |
| err_o | output | 1 | One-cycle pulse for a rejected divider pair |
| locked_o | output | 1 | Recovery lock active |

## Verification
Nearly every stored field is visible at code_o, n_o and m_o. They are combinational from the registers, so a wrongly stored byte field or a wrong priority shows up in the cycle right after the write edge. A faulty ratio compare shows up in the same cycle as a missing or spurious err_o pulse, with chg_o having the opposite value. A lock flag that fails to set or clear shows up at once: the writes that follow either move or fail to move the outputs, and the expected chg_o pulse at entry or exit is missing.

// File: rtl/freq_src_sel_pkg.sv
package freq_src_sel_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CODE_W = 5;
  localparam int unsigned N_W    = 8;
  localparam int unsigned M_W    = BYTE_W - 1;
  localparam int unsigned SPR_W  = 2;

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PROG_N = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PROG_M = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_RCV_N  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_RCV_M  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_GUARD  = ADDR_W'(5);

  // byte-0 bit position of select code bit i
  localparam int unsigned SEL_BIT [CODE_W] = '{4, 5, 6, 1, 2};
  localparam int unsigned OVR_BIT    = 3;
  localparam int unsigned SPR_HI_BIT = 7;
  localparam int unsigned SPR_LO_BIT = 0;
  localparam int unsigned EN_BIT     = BYTE_W - 1;

  typedef struct packed {
    logic [CODE_W-1:0] sel;
    logic              ovr;
    logic [SPR_W-1:0]  spr;
    logic              pen;
    logic [N_W-1:0]    n;
    logic [M_W-1:0]    m;
    logic              rsel;
    logic [N_W-1:0]    rn;
    logic [M_W-1:0]    rm;
    logic              arm;
  } cfg_t;

  // (n+3) > (m+3), evaluated without wrap
  function automatic logic ratio_ok(input logic [N_W-1:0] n, input logic [M_W-1:0] m);
    logic [N_W:0] nn;
    logic [N_W:0] mm;
    nn = (N_W+1)'(n) + (N_W+1)'(3);
    mm = (N_W+1)'(m) + (N_W+1)'(3);
    return nn > mm;
  endfunction
endpackage

// File: rtl/freq_src_sel_strap.sv
module freq_src_sel_strap
  import freq_src_sel_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwrgd_ni,
  input  logic [CODE_W-1:0] strap_i,
  output logic              ready_o,
  output logic [CODE_W-1:0] strap_o
);
  logic              rdy_q;
  logic [CODE_W-1:0] strap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q   <= 1'b0;
      strap_q <= '0;
    end else if (!rdy_q && !pwrgd_ni) begin
      rdy_q   <= 1'b1;
      strap_q <= strap_i;
    end
  end

  assign ready_o = rdy_q;
  assign strap_o = strap_q;
endmodule

// File: rtl/freq_src_sel_regs.sv
module freq_src_sel_regs
  import freq_src_sel_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ready_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              recover_req_i,
  output cfg_t              cfg_o,
  output logic              lock_o,
  output logic              chg_o,
  output logic              err_o
);
  cfg_t              cfg_q, cfg_d;
  logic              lock_q, lock_d;
  logic              chg_q, chg_d;
  logic              err_q, err_d;
  logic              lock_set, wr_ok;
  logic [CODE_W-1:0] sel_wr;
  logic [N_W-1:0]    n_wr;
  logic [M_W-1:0]    m_wr;
  logic              en_wr;

  for (genvar i = 0; i < CODE_W; i++) begin : g_sel
    assign sel_wr[i] = wr_data_i[SEL_BIT[i]];
  end

  assign n_wr  = wr_data_i[N_W-1:0];
  assign m_wr  = wr_data_i[M_W-1:0];
  assign en_wr = wr_data_i[EN_BIT];

  // recovery entry wins over a same-cycle write
  assign lock_set = recover_req_i && ready_i && cfg_q.arm && !lock_q;
  assign wr_ok    = wr_en_i && ready_i && !lock_set;

  always_comb begin
    cfg_d  = cfg_q;
    lock_d = lock_q || lock_set;
    chg_d  = lock_set;
    err_d  = 1'b0;
    if (wr_ok) begin
      case (wr_addr_i)
        A_CTRL: if (!lock_q) begin
          cfg_d.sel = sel_wr;
          cfg_d.ovr = wr_data_i[OVR_BIT];
          cfg_d.spr = {wr_data_i[SPR_HI_BIT], wr_data_i[SPR_LO_BIT]};
          chg_d     = 1'b1;
        end
        A_PROG_N: if (!lock_q) begin
          if (!cfg_q.pen || ratio_ok(n_wr, cfg_q.m)) begin
            cfg_d.n = n_wr;
            chg_d   = 1'b1;
          end else err_d = 1'b1;
        end
        A_PROG_M: if (!lock_q) begin
          if (!en_wr || ratio_ok(cfg_q.n, m_wr)) begin
            cfg_d.pen = en_wr;
            cfg_d.m   = m_wr;
            chg_d     = 1'b1;
          end else err_d = 1'b1;
        end
        A_RCV_N: if (!lock_q) begin
          if (!cfg_q.rsel || ratio_ok(n_wr, cfg_q.rm)) cfg_d.rn = n_wr;
          else err_d = 1'b1;
        end
        A_RCV_M: if (!lock_q) begin
          if (!en_wr || ratio_ok(cfg_q.rn, m_wr)) begin
            cfg_d.rsel = en_wr;
            cfg_d.rm   = m_wr;
          end else err_d = 1'b1;
        end
        A_GUARD: begin
          cfg_d.arm = wr_data_i[0];
          if (!wr_data_i[0]) begin
            lock_d = 1'b0;
            chg_d  = lock_q;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      lock_q <= 1'b0;
      chg_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      lock_q <= lock_d;
      chg_q  <= chg_d;
      err_q  <= err_d;
    end
  end

  assign cfg_o  = cfg_q;
  assign lock_o = lock_q;
  assign chg_o  = chg_q;
  assign err_o  = err_q;
endmodule

// File: rtl/freq_src_sel_mux.sv
module freq_src_sel_mux
  import freq_src_sel_pkg::*;
(
  input  logic              ready_i,
  input  logic [CODE_W-1:0] strap_i,
  input  cfg_t              cfg_i,
  input  logic              lock_i,
  output logic [CODE_W-1:0] code_o,
  output logic              mode_o,
  output logic [N_W-1:0]    n_o,
  output logic [M_W-1:0]    m_o,
  output logic [SPR_W-1:0]  spread_o
);
  always_comb begin
    code_o   = cfg_i.ovr ? cfg_i.sel : strap_i;
    mode_o   = cfg_i.pen;
    n_o      = cfg_i.n;
    m_o      = cfg_i.m;
    spread_o = cfg_i.spr;
    if (lock_i) begin
      if (cfg_i.rsel) begin
        mode_o = 1'b1;
        n_o    = cfg_i.rn;
        m_o    = cfg_i.rm;
      end else begin
        mode_o = 1'b0;
        code_o = strap_i;
      end
    end
    if (!mode_o) begin
      n_o = '0;
      m_o = '0;
    end
    if (!ready_i) begin
      code_o   = '0;
      mode_o   = 1'b0;
      n_o      = '0;
      m_o      = '0;
      spread_o = '0;
    end
  end
endmodule

// File: rtl/freq_src_sel.sv
module freq_src_sel
  import freq_src_sel_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwrgd_ni,
  input  logic [CODE_W-1:0] strap_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              recover_req_i,
  output logic              ready_o,
  output logic [CODE_W-1:0] code_o,
  output logic              prog_mode_o,
  output logic [N_W-1:0]    n_o,
  output logic [M_W-1:0]    m_o,
  output logic [SPR_W-1:0]  spread_o,
  output logic              chg_o,
  output logic              err_o,
  output logic              locked_o
);
  logic              ready;
  logic [CODE_W-1:0] strap_lat;
  cfg_t              cfg;
  logic              lock;

  freq_src_sel_strap u_strap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwrgd_ni (pwrgd_ni),
    .strap_i  (strap_i),
    .ready_o  (ready),
    .strap_o  (strap_lat)
  );

  freq_src_sel_regs u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ready_i       (ready),
    .wr_en_i       (wr_en_i),
    .wr_addr_i     (wr_addr_i),
    .wr_data_i     (wr_data_i),
    .recover_req_i (recover_req_i),
    .cfg_o         (cfg),
    .lock_o        (lock),
    .chg_o         (chg_o),
    .err_o         (err_o)
  );

  freq_src_sel_mux u_mux (
    .ready_i  (ready),
    .strap_i  (strap_lat),
    .cfg_i    (cfg),
    .lock_i   (lock),
    .code_o   (code_o),
    .mode_o   (prog_mode_o),
    .n_o      (n_o),
    .m_o      (m_o),
    .spread_o (spread_o)
  );

  assign ready_o  = ready;
  assign locked_o = lock;
endmodule

// File: rtl/freq_src_sel_chk.sv
module freq_src_sel_chk
  import freq_src_sel_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              recover_req_i,
  input logic              ready_o,
  input logic [CODE_W-1:0] code_o,
  input logic              prog_mode_o,
  input logic [N_W-1:0]    n_o,
  input logic [M_W-1:0]    m_o,
  input logic              chg_o,
  input logic              err_o,
  input logic              locked_o
);
  a_r1_quiet_before_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (code_o == '0 && n_o == '0 && m_o == '0 && !prog_mode_o && !locked_o));

  a_r1_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  a_r6_active_ratio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_mode_o |-> ratio_ok(n_o, m_o));

  a_r6_err_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !chg_o);

  a_r7_strobe_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |-> $past(wr_en_i || recover_req_i));

  a_r8_lock_from_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> ($past(recover_req_i) && chg_o));

  a_r10_lock_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && $past(locked_o)) |-> ($stable(code_o) && $stable(n_o) && $stable(m_o) && !err_o));

  a_r11_unlock_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> ($past(wr_en_i) && chg_o));
endmodule

bind freq_src_sel freq_src_sel_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .recover_req_i (recover_req_i),
  .ready_o       (ready_o),
  .code_o        (code_o),
  .prog_mode_o   (prog_mode_o),
  .n_o           (n_o),
  .m_o           (m_o),
  .chg_o         (chg_o),
  .err_o         (err_o),
  .locked_o      (locked_o)
);

// File: tb/freq_src_sel_tb_top.sv
`timescale 1ns/1ps
module freq_src_sel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwrgd_n = 1'b1;
  logic [4:0] strap = 5'b10110;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rreq = 1'b0;
  logic       ready, mode, chg, err, lock;
  logic [4:0] code;
  logic [7:0] n;
  logic [6:0] m;
  logic [1:0] spr;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [4:0] STRAP = 5'b10110;
  localparam logic [4:0] SELX  = 5'b01101;

  always #4 clk = ~clk;

  freq_src_sel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwrgd_ni(pwrgd_n), .strap_i(strap),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .recover_req_i(rreq),
    .ready_o(ready), .code_o(code), .prog_mode_o(mode), .n_o(n), .m_o(m),
    .spread_o(spr), .chg_o(chg), .err_o(err), .locked_o(lock)
  );

  // {addr, data, code, mode, n, m, chg, err}
  localparam int NV = 13;
  localparam logic [34:0] VEC [NV] = '{
    {4'd0, 8'h00, STRAP, 1'b0, 8'd0,   7'd0,  1'b1, 1'b0}, // R7 same value strobes
    {4'd0, 8'h5A, SELX,  1'b0, 8'd0,   7'd0,  1'b1, 1'b0}, // R2 R3 override
    {4'd1, 8'd97, SELX,  1'b0, 8'd0,   7'd0,  1'b1, 1'b0}, // R5 N stored, not shown
    {4'd2, 8'hDD, SELX,  1'b1, 8'd97,  7'd93, 1'b1, 1'b0}, // R4 enable M=93
    {4'd1, 8'd93, SELX,  1'b1, 8'd97,  7'd93, 1'b0, 1'b1}, // R6 N==M
    {4'd2, 8'hE1, SELX,  1'b1, 8'd97,  7'd93, 1'b0, 1'b1}, // R6 M==N
    {4'd1, 8'hFF, SELX,  1'b1, 8'd255, 7'd93, 1'b1, 1'b0}, // R4 N=255
    {4'd2, 8'hDD, SELX,  1'b1, 8'd255, 7'd93, 1'b1, 1'b0}, // R7 identical M
    {4'd0, 8'h00, STRAP, 1'b1, 8'd255, 7'd93, 1'b1, 1'b0}, // R4 ratio from strap
    {4'd3, 8'h7F, STRAP, 1'b1, 8'd255, 7'd93, 1'b0, 1'b0}, // R5 R7 recovery N no strobe
    {4'd4, 8'hAD, STRAP, 1'b1, 8'd255, 7'd93, 1'b0, 1'b0}, // R5 recovery M=45 sel=1
    {4'd4, 8'hFF, STRAP, 1'b1, 8'd255, 7'd93, 1'b0, 1'b1}, // R6 recovery pair bad
    {4'd2, 8'h05, STRAP, 1'b0, 8'd0,   7'd0,  1'b1, 1'b0}  // R3 disable, no check
  };

  task automatic cmp(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [4:0] ec, input logic em,
                         input logic [7:0] en, input logic [6:0] emm,
                         input logic ech, input logic eer, input logic elk);
    checks++;
    if (code !== ec || mode !== em || n !== en || m !== emm ||
        chg !== ech || err !== eer || lock !== elk) begin
      errors++;
      $display("FAIL %s: actual code=%b mode=%b n=%0d m=%0d chg=%b err=%b lock=%b expected code=%b mode=%b n=%0d m=%0d chg=%b err=%b lock=%b",
               req, code, mode, n, m, chg, err, lock, ec, em, en, emm, ech, eer, elk);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic req();
    @(negedge clk);
    rreq = 1'b1;
    @(negedge clk);
    rreq = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 ready after reset", ready, 0);
    chk_all("R1 reset outputs", 5'd0, 0, 8'd0, 7'd0, 0, 0, 0);
    cmp("R1 spread after reset", spr, 0);

    wr(4'd0, 8'h5A);
    chk_all("R12 write before ready", 5'd0, 0, 8'd0, 7'd0, 0, 0, 0);

    @(negedge clk);
    pwrgd_n = 1'b0;
    @(negedge clk);
    cmp("R1 ready after power good", ready, 1);
    chk_all("R12 R1 strap code active", STRAP, 0, 8'd0, 7'd0, 0, 0, 0);
    strap = 5'b00001;
    repeat (2) @(negedge clk);
    chk_all("R1 strap change ignored", STRAP, 0, 8'd0, 7'd0, 0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][34:31], VEC[i][30:23]);
      chk_all($sformatf("R2-table vector %0d", i), VEC[i][22:18], VEC[i][17],
              VEC[i][16:9], VEC[i][8:2], VEC[i][1], VEC[i][0], 1'b0);
    end

    wr(4'd0, 8'h81);
    cmp("R2 spread bits 7,0 = 11", spr, 3);
    wr(4'd0, 8'h80);
    cmp("R2 spread bits 7,0 = 10", spr, 2);
    wr(4'd0, 8'h00);

    wr(4'd5, 8'h01);
    chk_all("R5 arm gives no strobe", STRAP, 0, 8'd0, 7'd0, 0, 0, 0);
    req();
    chk_all("R8 R9 recovery pair locked", STRAP, 1, 8'd127, 7'd45, 1, 0, 1);
    @(negedge clk);
    chk_all("R7 strobe lasts one cycle", STRAP, 1, 8'd127, 7'd45, 0, 0, 1);
    wr(4'd0, 8'h5A);
    chk_all("R10 control write ignored", STRAP, 1, 8'd127, 7'd45, 0, 0, 1);
    wr(4'd2, 8'hDD);
    chk_all("R10 M write ignored", STRAP, 1, 8'd127, 7'd45, 0, 0, 1);
    wr(4'd1, 8'h00);
    chk_all("R10 bad N write ignored without error", STRAP, 1, 8'd127, 7'd45, 0, 0, 1);
    req();
    chk_all("R8 request while locked", STRAP, 1, 8'd127, 7'd45, 0, 0, 1);
    wr(4'd5, 8'h00);
    chk_all("R11 unlock strobes", STRAP, 0, 8'd0, 7'd0, 1, 0, 0);
    req();
    chk_all("R8 request while unarmed", STRAP, 0, 8'd0, 7'd0, 0, 0, 0);

    wr(4'd4, 8'h2D);
    chk_all("R5 recovery select cleared", STRAP, 0, 8'd0, 7'd0, 0, 0, 0);
    wr(4'd0, 8'h5A);
    chk_all("R3 override active", SELX, 0, 8'd0, 7'd0, 1, 0, 0);
    wr(4'd5, 8'h01);
    req();
    chk_all("R9 strap recovery forces strap code", STRAP, 0, 8'd0, 7'd0, 1, 0, 1);
    wr(4'd5, 8'h00);
    chk_all("R11 unlock back to override code", SELX, 0, 8'd0, 7'd0, 1, 0, 0);
    wr(4'd5, 8'h00);
    chk_all("R11 unlock when not locked no strobe", SELX, 0, 8'd0, 7'd0, 0, 0, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule